// File: doc/BRIEF.md
# Conjugate Cross-Multiply Correlator with Bin Combining and Time Integration

This block takes two time-aligned streams of fine-channel samples, one from each of two signal paths. Each sample is complex, with a 4-bit two's-complement real part and a 4-bit two's-complement imaginary part. Both streams carry every fine bin of a time step in rising index order. A time step holds `NGROUP` groups of `GRP` bins; the default is 24 groups of 128, or 3072 bins. For each bin the block multiplies the first stream by the complex conjugate of the second. It then adds each run of C adjacent fine bins into one composite bin and sums every composite bin over a chosen number of time steps. At the end of each integration period it emits the integrated visibility of each composite bin.

C is a power of two, so it always divides the group size. It is set by `cfg_log2c`. The integration length is set by `cfg_tsteps`. Both settings are held steady while a run is in progress. Running sums live in a memory indexed by composite bin. Each composite result leaves the block as soon as its last contribution of the period has been added. The next period then starts again from zero. An integration period that has not completed when the input stops is never emitted.

Top module: `xcorr_accum`

## Requirements
- R1: A sample pair is taken only on a cycle where `a_valid` and `b_valid` are both high and `a_bin` equals `b_bin`. On any other cycle the inputs have no effect on any result and do not advance the time-step count.
- R2: The product of a pair is exact, with real part ar·br + ai·bi and imaginary part ai·br − ar·bi.
- R3: Composite bin j holds fine bins j·C through j·C+C−1, where C = 2^`cfg_log2c`. Values of `cfg_log2c` above log2(`GRP`) act as log2(`GRP`). `out_bin` carries j.
- R4: A time step ends with the taken pair whose bin index is `NBINS`−1. An integration period spans `cfg_tsteps` time steps, and a setting of 0 acts as 1.
- R5: The result for composite bin j appears with `out_valid` high two clock edges after the edge that takes the pair carrying the last fine bin of that composite in the last time step of the period.
- R6: Each period's sums start from zero and contain nothing from earlier periods or from memory contents present before reset.
- R7: An incomplete trailing period produces no output.
- R8: Pairs arriving back to back on the same composite bin, or separated by idle cycles, all contribute to the sum.
- R9: The result fields are `ACCW` = 9 + log2(`GRP`) + `TW` bits wide. They hold the full-scale sum exactly (all inputs −8, largest C, largest count).
- R10: During reset and on the first cycle after it, `out_valid` is low, and the next period starts at time step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Stream A sample present |
| a_bin | input | BINW | Stream A fine-bin index |
| a_re | input | 4 | Stream A real part, signed |
| a_im | input | 4 | Stream A imaginary part, signed |
| b_valid | input | 1 | Stream B sample present |
| b_bin | input | BINW | Stream B fine-bin index |
| b_re | input | 4 | Stream B real part, signed |
| b_im | input | 4 | Stream B imaginary part, signed |
| cfg_log2c | input | SHW | log2 of the number of fine bins per composite bin |
| cfg_tsteps | input | TW | Time steps per integration period (0 acts as 1) |
| out_valid | output | 1 | Integrated result present |
| out_bin | output | BINW | Composite bin index of the result |
| out_re | output | ACCW | Integrated real part, signed |
| out_im | output | ACCW | Integrated imaginary part, signed |

## Verification
The bench sweeps every combining factor of a small configuration, including an out-of-range setting that must clamp. It uses several integration lengths and multi-period runs, and compares every emitted value with a sum computed directly from the sample formula.

Several corner cases are targeted. Back-to-back pairs on one composite address would lose contributions if the read-modify-write bypass were wrong. Later periods would carry earlier sums if the clear were missing. The output count would grow if a trailing partial period leaked out. Idle cycles are filled with half-valid or bin-mismatched junk, which would corrupt sums or shift the time-step count if it were accepted. An all-minus-eight run at the longest period would wrap a narrowed accumulator.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;

    localparam int SW = 4;
    localparam int PW = 2 * SW + 1;

    typedef struct packed {
        logic signed [SW-1:0] re;
        logic signed [SW-1:0] im;
    } samp_t;

    typedef struct packed {
        logic signed [PW-1:0] re;
        logic signed [PW-1:0] im;
    } prod_t;

    function automatic logic signed [PW-1:0] widen(input logic signed [SW-1:0] v);
        return {{(PW-SW){v[SW-1]}}, v};
    endfunction

    // a * conj(b), exact at PW bits
    function automatic prod_t conj_mult(input samp_t a, input samp_t b);
        prod_t p;
        logic signed [PW-1:0] ar, ai, br, bi;
        ar = widen(a.re);
        ai = widen(a.im);
        br = widen(b.re);
        bi = widen(b.im);
        p.re = ar * br + ai * bi;
        p.im = ai * br - ar * bi;
        return p;
    endfunction

endpackage

// File: rtl/xc_step_ctrl.sv
module xc_step_ctrl #(
    parameter int NBINS = 3072,
    parameter int BINW  = 12,
    parameter int LOG2G = 7,
    parameter int SHW   = 3,
    parameter int TW    = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pair,
    input  logic [BINW-1:0] bin,
    input  logic [SHW-1:0]  cfg_log2c,
    input  logic [TW-1:0]   cfg_tsteps,
    output logic [BINW-1:0] addr,
    output logic            first,
    output logic            last
);

    logic [SHW-1:0]  shift;
    logic [BINW-1:0] mask;
    logic [TW-1:0]   t_final;
    logic [TW-1:0]   ts_cnt;
    logic            step_end;

    always_comb begin
        shift    = (cfg_log2c > SHW'(LOG2G)) ? SHW'(LOG2G) : cfg_log2c;
        mask     = ~({BINW{1'b1}} << shift);
        t_final  = (cfg_tsteps == '0) ? '0 : cfg_tsteps - 1'b1;
        step_end = pair && (bin == BINW'(NBINS - 1));
        addr     = bin >> shift;
        first    = (ts_cnt == '0) && ((bin & mask) == '0);
        last     = (ts_cnt == t_final) && ((bin & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_cnt <= '0;
        end else if (step_end) begin
            ts_cnt <= (ts_cnt == t_final) ? '0 : ts_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/xc_prod_stage.sv
module xc_prod_stage
    import xcorr_pkg::*;
#(
    parameter int BINW = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  samp_t           a,
    input  samp_t           b,
    input  logic [BINW-1:0] in_addr,
    input  logic            in_first,
    input  logic            in_last,
    output logic            s1_vld,
    output logic [BINW-1:0] s1_addr,
    output logic            s1_first,
    output logic            s1_last,
    output prod_t           s1_prod
);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
        end else begin
            s1_vld <= in_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (in_vld) begin
            s1_addr  <= in_addr;
            s1_first <= in_first;
            s1_last  <= in_last;
            s1_prod  <= conj_mult(a, b);
        end
    end

endmodule

// File: rtl/xc_accum_mem.sv
module xc_accum_mem
    import xcorr_pkg::*;
#(
    parameter int DEPTH = 3072,
    parameter int BINW  = 12,
    parameter int ACCW  = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_vld,
    input  logic [BINW-1:0]        rd_addr,
    input  logic                   s1_vld,
    input  logic [BINW-1:0]        s1_addr,
    input  logic                   s1_first,
    input  logic                   s1_last,
    input  prod_t                  s1_prod,
    output logic                   out_valid,
    output logic [BINW-1:0]        out_bin,
    output logic signed [ACCW-1:0] out_re,
    output logic signed [ACCW-1:0] out_im
);

    logic signed [ACCW-1:0] mem_re [DEPTH];
    logic signed [ACCW-1:0] mem_im [DEPTH];
    logic signed [ACCW-1:0] rd_re, rd_im;
    logic signed [ACCW-1:0] wr_re, wr_im;
    logic signed [ACCW-1:0] base_re, base_im;
    logic signed [ACCW-1:0] sum_re, sum_im;
    logic                   fwd_q;

    always_comb begin
        if (s1_first) begin
            base_re = '0;
            base_im = '0;
        end else if (fwd_q) begin
            base_re = wr_re;
            base_im = wr_im;
        end else begin
            base_re = rd_re;
            base_im = rd_im;
        end
        sum_re = base_re + {{(ACCW-PW){s1_prod.re[PW-1]}}, s1_prod.re};
        sum_im = base_im + {{(ACCW-PW){s1_prod.im[PW-1]}}, s1_prod.im};
    end

    // storage: read issued one stage ahead of the write
    always_ff @(posedge clk) begin
        if (rd_vld) begin
            rd_re <= mem_re[rd_addr];
            rd_im <= mem_im[rd_addr];
        end
        if (s1_vld) begin
            mem_re[s1_addr] <= sum_re;
            mem_im[s1_addr] <= sum_im;
            wr_re           <= sum_re;
            wr_im           <= sum_im;
        end
    end

    // same address written while read: take the written value next cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_q     <= 1'b0;
            out_valid <= 1'b0;
            out_bin   <= '0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            fwd_q     <= rd_vld && s1_vld && (rd_addr == s1_addr);
            out_valid <= s1_vld && s1_last;
            if (s1_vld && s1_last) begin
                out_bin <= s1_addr;
                out_re  <= sum_re;
                out_im  <= sum_im;
            end
        end
    end

endmodule

// File: rtl/xcorr_accum.sv
module xcorr_accum
    import xcorr_pkg::*;
#(
    parameter int NGROUP = 24,
    parameter int GRP    = 128,
    parameter int TW     = 16,
    localparam int NBINS = NGROUP * GRP,
    localparam int BINW  = $clog2(NBINS),
    localparam int LOG2G = $clog2(GRP),
    localparam int SHW   = $clog2(LOG2G + 1),
    localparam int ACCW  = PW + LOG2G + TW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   a_valid,
    input  logic [BINW-1:0]        a_bin,
    input  logic signed [SW-1:0]   a_re,
    input  logic signed [SW-1:0]   a_im,
    input  logic                   b_valid,
    input  logic [BINW-1:0]        b_bin,
    input  logic signed [SW-1:0]   b_re,
    input  logic signed [SW-1:0]   b_im,
    input  logic [SHW-1:0]         cfg_log2c,
    input  logic [TW-1:0]          cfg_tsteps,
    output logic                   out_valid,
    output logic [BINW-1:0]        out_bin,
    output logic signed [ACCW-1:0] out_re,
    output logic signed [ACCW-1:0] out_im
);

    logic            pair;
    samp_t           sa, sb;
    logic [BINW-1:0] s0_addr;
    logic            s0_first, s0_last;
    logic            s1_vld, s1_first, s1_last;
    logic [BINW-1:0] s1_addr;
    prod_t           s1_prod;

    always_comb begin
        pair  = a_valid && b_valid && (a_bin == b_bin);
        sa.re = a_re;
        sa.im = a_im;
        sb.re = b_re;
        sb.im = b_im;
    end

    xc_step_ctrl #(
        .NBINS(NBINS), .BINW(BINW), .LOG2G(LOG2G), .SHW(SHW), .TW(TW)
    ) u_ctrl (
        .clk(clk), .rst(rst), .pair(pair), .bin(a_bin),
        .cfg_log2c(cfg_log2c), .cfg_tsteps(cfg_tsteps),
        .addr(s0_addr), .first(s0_first), .last(s0_last)
    );

    xc_prod_stage #(.BINW(BINW)) u_prod (
        .clk(clk), .rst(rst), .in_vld(pair), .a(sa), .b(sb),
        .in_addr(s0_addr), .in_first(s0_first), .in_last(s0_last),
        .s1_vld(s1_vld), .s1_addr(s1_addr), .s1_first(s1_first),
        .s1_last(s1_last), .s1_prod(s1_prod)
    );

    xc_accum_mem #(.DEPTH(NBINS), .BINW(BINW), .ACCW(ACCW)) u_mem (
        .clk(clk), .rst(rst), .rd_vld(pair), .rd_addr(s0_addr),
        .s1_vld(s1_vld), .s1_addr(s1_addr), .s1_first(s1_first),
        .s1_last(s1_last), .s1_prod(s1_prod),
        .out_valid(out_valid), .out_bin(out_bin),
        .out_re(out_re), .out_im(out_im)
    );

endmodule

// File: rtl/xcorr_accum_chk.sv
module xcorr_accum_chk #(
    parameter int NGROUP = 24,
    parameter int GRP    = 128,
    parameter int TW     = 16,
    localparam int NBINS = NGROUP * GRP,
    localparam int BINW  = $clog2(NBINS),
    localparam int LOG2G = $clog2(GRP),
    localparam int SHW   = $clog2(LOG2G + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            a_valid,
    input logic [BINW-1:0] a_bin,
    input logic            b_valid,
    input logic [BINW-1:0] b_bin,
    input logic [SHW-1:0]  cfg_log2c,
    input logic            out_valid,
    input logic [BINW-1:0] out_bin
);

    logic           taken, mismatch;
    logic [SHW-1:0] eff_sh;

    always_comb begin
        taken    = a_valid && b_valid && (a_bin == b_bin);
        mismatch = a_valid && b_valid && (a_bin != b_bin);
        eff_sh   = (int'(cfg_log2c) > LOG2G) ? SHW'(LOG2G) : cfg_log2c;
    end

    a_r10_idle_after_reset: assert property (@(posedge clk) rst |=> !out_valid);

    a_r5_out_needs_pair: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(taken, 2));

    a_r1_mismatch_no_out: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> ##1 !out_valid);

    a_r3_out_bin_from_index: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_bin == ($past(a_bin, 2) >> eff_sh)));

    a_r3_out_bin_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_bin) < (NBINS >> eff_sh)));

endmodule

bind xcorr_accum xcorr_accum_chk #(.NGROUP(NGROUP), .GRP(GRP), .TW(TW)) u_chk (.*);

// File: tb/xcorr_accum_tb.sv
module xcorr_accum_tb;

    localparam int NGROUP = 2;
    localparam int GRP    = 4;
    localparam int TW     = 4;
    localparam int NBINS  = NGROUP * GRP;
    localparam int BINW   = $clog2(NBINS);
    localparam int LG     = $clog2(GRP);
    localparam int SHW    = $clog2(LG + 1);
    localparam int ACCW   = 9 + LG + TW;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   a_valid = 1'b0, b_valid = 1'b0;
    logic [BINW-1:0]        a_bin = '0, b_bin = '0;
    logic signed [3:0]      a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic [SHW-1:0]         cfg_log2c = '0;
    logic [TW-1:0]          cfg_tsteps = '0;
    logic                   out_valid;
    logic [BINW-1:0]        out_bin;
    logic signed [ACCW-1:0] out_re, out_im;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int oc     = 0;
    int cur_c  = 1;
    int cur_t  = 1;
    int mode   = 0;
    int seed   = 0;

    always #2 clk = ~clk;

    xcorr_accum #(.NGROUP(NGROUP), .GRP(GRP), .TW(TW)) u_dut (.*);

    function automatic int samp(int side, int part, int t, int b);
        if (mode == 1) return -8;
        return ((t * 5 + b * 3 + side * 7 + part * 11 + seed) % 16) - 8;
    endfunction

    task automatic expect_sum(int p, int j, output longint er, output longint ei);
        er = 0;
        ei = 0;
        for (int t = p * cur_t; t < (p + 1) * cur_t; t++) begin
            for (int b = j * cur_c; b < (j + 1) * cur_c; b++) begin
                er += samp(0, 0, t, b) * samp(1, 0, t, b) + samp(0, 1, t, b) * samp(1, 1, t, b);
                ei += samp(0, 1, t, b) * samp(1, 0, t, b) - samp(0, 0, t, b) * samp(1, 1, t, b);
            end
        end
    endtask

    // every emitted result checked against the arithmetic reference (R2 R3 R6 R8 R9)
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            int ncomp, p, j;
            longint er, ei;
            ncomp = NBINS / cur_c;
            p = oc / ncomp;
            j = oc % ncomp;
            expect_sum(p, j, er, ei);
            checks++;
            if (int'(out_bin) != j || longint'(out_re) != er || longint'(out_im) != ei) begin
                errors++;
                $display("FAIL R2/R3/R6/R8/R9 result %0d: got bin=%0d re=%0d im=%0d exp bin=%0d re=%0d im=%0d",
                         oc, out_bin, out_re, out_im, j, er, ei);
            end
            oc++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic idle(bit junk, int k);
        @(negedge clk);
        a_valid = 1'b0;
        b_valid = 1'b0;
        if (junk) begin
            // R1: half-valid or mismatched bins must have no effect
            a_re = 4'sh7; a_im = -4'sh8; b_re = -4'sh8; b_im = 4'sh7;
            a_bin = BINW'(NBINS - 1);
            if (k % 2 == 0) begin
                a_valid = 1'b1;
                b_bin = BINW'(NBINS - 1);
            end else begin
                a_valid = 1'b1;
                b_valid = 1'b1;
                b_bin = '0;
            end
        end
    endtask

    task automatic run(int lc_cfg, int lc_eff, int ts_cfg, int ts_eff, int m, int sd,
                       int steps, int extra_bins, bit gaps);
        int ncomp;
        @(negedge clk);
        rst = 1'b1;
        a_valid = 1'b0;
        b_valid = 1'b0;
        mode = m;
        seed = sd;
        cur_c = 1 << lc_eff;
        cur_t = ts_eff;
        cfg_log2c = SHW'(lc_cfg);
        cfg_tsteps = TW'(ts_cfg);
        repeat (2) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 out_valid in reset: got %b exp 0", out_valid);
        end
        oc = 0;
        rst = 1'b0;
        for (int t = 0; t <= steps; t++) begin
            for (int b = 0; b < NBINS; b++) begin
                if (t == steps && b >= extra_bins) break;
                @(negedge clk);
                a_valid = 1'b1;
                b_valid = 1'b1;
                a_bin = BINW'(b);
                b_bin = BINW'(b);
                a_re = 4'(samp(0, 0, t, b));
                a_im = 4'(samp(0, 1, t, b));
                b_re = 4'(samp(1, 0, t, b));
                b_im = 4'(samp(1, 1, t, b));
                if (gaps && ((t + b) % 3 == 0)) idle(1'b1, t + b);
            end
        end
        idle(1'b0, 0);
        repeat (6) @(negedge clk);
        ncomp = NBINS / cur_c;
        checks++;
        // R7: only complete periods produce output; R4: period length
        if (oc != (steps / ts_eff) * ncomp) begin
            errors++;
            $display("FAIL R4/R7 result count: got %0d exp %0d", oc, (steps / ts_eff) * ncomp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 initial out_valid: got %b exp 0", out_valid);
        end
        run(0, 0, 1, 1, 0, 0, 3, 0, 1'b0);   // R2 C=1
        run(1, 1, 2, 2, 0, 3, 4, 3, 1'b1);   // R1 R7 R8 gaps, junk, partial step
        run(2, 2, 3, 3, 0, 5, 7, 2, 1'b0);   // R6 R7 R8 back to back, partial period
        run(3, 2, 2, 2, 0, 9, 4, 0, 1'b1);   // R3 clamp of log2c
        run(1, 1, 0, 1, 0, 1, 2, 0, 1'b0);   // R4 count 0 acts as 1
        run(2, 2, 15, 15, 1, 0, 15, 0, 1'b0); // R9 full scale
        run(0, 0, 2, 2, 0, 12, 4, 5, 1'b1);  // R1 R5 C=1 with gaps
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule